// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block steps an 8-bit processor with a 16-bit program counter into and out of interrupt service. When it is idle it looks at four kinds of request: a non-maskable line that reacts to edges, a maskable level request that the interrupt-disable flag gates, a software break, and a return-from-interrupt. It accepts at most one of them. For an entry it writes the program counter and the status byte to the stack, reads a two-byte vector, and hands the core a new program counter and a new status byte. For a return it reads the status byte and the program counter back from the stack and hands them to the core.

The stack memory and the vector memory are outside the block. A push or a vector read takes one cycle, with the data on the port in that cycle. For a pull, the stack returns the byte on `pull_data` in the same cycle that `pull_vld` is high. `busy` stays high for the whole sequence. The core applies `pc_out` and `status_out` in the cycle that `pc_load` and `status_load` are high.

Top module: `intr_seq`

## Requirements
- R1: During reset and whenever the block is idle, `busy`, `push_vld`, `pull_vld`, `vec_rd`, `pc_load` and `status_load` are 0, and `push_data`, `vec_addr`, `pc_out` and `status_out` read 0.
- R2: An entry starts in the cycle after the request is accepted. Three pushes follow in consecutive cycles: PC[15:8] first, then PC[7:0], then the status byte. The PC and status are the values of `pc_in` and `status_in` captured in the accepting cycle.
- R3: The pushed status byte has bit 5 set. Bit 4 is 1 for a software break and 0 for a maskable or non-maskable hardware entry. The other bits are copied from the captured status.
- R4: After the pushes, a maskable or break entry reads address 0xFFFE and then 0xFFFF in the next two cycles. In the second read cycle, `pc_load` is high and `pc_out` = {byte at 0xFFFF, byte at 0xFFFE}.
- R5: A non-maskable entry reads 0xFFFA and then 0xFFFB in the same way, and loads the PC from them.
- R6: The maskable request is ignored while `i_flag` is 1. The non-maskable request is taken whatever the value of `i_flag`.
- R7: The non-maskable input is edge-sensitive. A level held high gives exactly one entry. A rising edge seen while the block is busy is kept and is taken in the first idle cycle.
- R8: When several requests are present in the same idle cycle, the priority is non-maskable, then unmasked maskable, then break, then return. Requests that lose are not remembered.
- R9: In the cycle that loads the PC on entry, `status_load` is high and `status_out` is the captured status with bit 2 (interrupt disable) set.
- R10: A return pulls three bytes in consecutive cycles: status, then PC[7:0], then PC[15:8]. In the third cycle, `pc_load` and `status_load` are high, `pc_out` = {third byte, second byte}, and `status_out` is the first byte with bit 4 cleared and bit 5 set.
- R11: `busy` is high in every cycle of a sequence (5 cycles for an entry, 3 for a return). Level requests that are present while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi | input | 1 | Non-maskable request, edge-sensitive |
| irq | input | 1 | Maskable request, level |
| i_flag | input | 1 | Interrupt-disable flag from the core |
| brk_req | input | 1 | Software break request |
| rti_req | input | 1 | Return-from-interrupt request |
| pc_in | input | 16 | Current program counter |
| status_in | input | 8 | Current status byte |
| push_vld | output | 1 | Stack write strobe |
| push_data | output | 8 | Byte to write to the stack |
| pull_vld | output | 1 | Stack read strobe |
| pull_data | input | 8 | Byte read from the stack |
| vec_rd | output | 1 | Vector read strobe |
| vec_addr | output | 16 | Vector byte address |
| vec_data | input | 8 | Vector byte read |
| pc_load | output | 1 | Load `pc_out` into the PC |
| pc_out | output | 16 | New program counter |
| status_load | output | 1 | Load `status_out` into the status register |
| status_out | output | 8 | New status byte |
| busy | output | 1 | Sequence in progress |

## Verification
A reference model in the bench keeps its own stack. It is checked against the design in every cycle through a series of request patterns:
- Maskable, break and non-maskable entries, each followed by a return. These separate the B bit in the pushed status and show which vector is used.
- A return from bytes that the bench itself placed on the stack, with bit 4 set. This shows that the pull order is the reverse of the push order and that bit 4 is cleared on restore.
- A maskable request held while the mask is set, and a non-maskable level held across many cycles. These separate masking from edge detection.
- Requests that collide in one idle cycle, and a non-maskable edge during a maskable entry. These check the priority order and the kept pending edge.

// File: rtl/intr_seq_pkg.sv
`timescale 1ns/1ps
package intr_seq_pkg;

  localparam int ST_W  = 8;
  localparam int BIT_I = 2;
  localparam int BIT_B = 4;
  localparam int BIT_U = 5;

  typedef enum logic [1:0] {K_IRQ, K_NMI, K_BRK, K_RTI} kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PCH, S_PCL, S_PSR, S_VLO, S_VHI, S_RP, S_RL, S_RH
  } state_e;

  // status byte as written to the stack on entry
  function automatic logic [ST_W-1:0] stacked_status(input logic [ST_W-1:0] st,
                                                     input logic from_brk);
    logic [ST_W-1:0] r;
    r        = st;
    r[BIT_U] = 1'b1;
    r[BIT_B] = from_brk;
    return r;
  endfunction

  // status handed to the core when service begins
  function automatic logic [ST_W-1:0] entry_status(input logic [ST_W-1:0] st);
    logic [ST_W-1:0] r;
    r        = st;
    r[BIT_I] = 1'b1;
    return r;
  endfunction

  // status handed to the core on return
  function automatic logic [ST_W-1:0] restored_status(input logic [ST_W-1:0] st);
    logic [ST_W-1:0] r;
    r        = st;
    r[BIT_B] = 1'b0;
    r[BIT_U] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/intr_seq_arb.sv
`timescale 1ns/1ps
module intr_seq_arb (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idle,
  input  logic                 nmi,
  input  logic                 irq,
  input  logic                 i_flag,
  input  logic                 brk_req,
  input  logic                 rti_req,
  output logic                 start,
  output intr_seq_pkg::kind_e  kind,
  output logic                 nmi_take
);
  import intr_seq_pkg::*;

  logic nmi_prev, nmi_pend;
  logic nmi_edge, nmi_want, irq_ok;

  assign nmi_edge = nmi & ~nmi_prev;
  assign nmi_want = nmi_pend | nmi_edge;
  assign irq_ok   = irq & ~i_flag;
  assign nmi_take = idle & nmi_want;
  assign start    = idle & (nmi_want | irq_ok | brk_req | rti_req);

  always_comb begin
    if (nmi_want)     kind = K_NMI;
    else if (irq_ok)  kind = K_IRQ;
    else if (brk_req) kind = K_BRK;
    else              kind = K_RTI;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi;
      nmi_pend <= nmi_want & ~nmi_take;
    end
  end
endmodule

// File: rtl/intr_seq_fsm.sv
`timescale 1ns/1ps
module intr_seq_fsm #(
  parameter int              DW      = 8,
  parameter logic [2*DW-1:0] NMI_VEC = 16'hFFFA,
  parameter logic [2*DW-1:0] IRQ_VEC = 16'hFFFE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  intr_seq_pkg::kind_e  kind,
  input  logic [2*DW-1:0]      pc_in,
  input  logic [7:0]           status_in,
  input  logic [DW-1:0]        pull_data,
  input  logic [DW-1:0]        vec_data,
  output logic                 push_vld,
  output logic [DW-1:0]        push_data,
  output logic                 pull_vld,
  output logic                 vec_rd,
  output logic [2*DW-1:0]      vec_addr,
  output logic                 pc_load,
  output logic [2*DW-1:0]      pc_out,
  output logic                 status_load,
  output logic [7:0]           status_out,
  output logic                 busy
);
  import intr_seq_pkg::*;
  localparam int AW = 2 * DW;

  state_e         state, state_nx;
  logic [AW-1:0]  pc_q, vbase_q;
  logic [7:0]     st_q, pst_q;
  logic [DW-1:0]  lo_q;
  logic           brk_q;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE: if (start) state_nx = (kind == K_RTI) ? S_RP : S_PCH;
      S_PCH:  state_nx = S_PCL;
      S_PCL:  state_nx = S_PSR;
      S_PSR:  state_nx = S_VLO;
      S_VLO:  state_nx = S_VHI;
      S_VHI:  state_nx = S_IDLE;
      S_RP:   state_nx = S_RL;
      S_RL:   state_nx = S_RH;
      S_RH:   state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pc_q    <= '0;
      vbase_q <= '0;
      st_q    <= '0;
      pst_q   <= '0;
      lo_q    <= '0;
      brk_q   <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == S_IDLE && start) begin
        pc_q    <= pc_in;
        st_q    <= status_in;
        brk_q   <= (kind == K_BRK);
        vbase_q <= (kind == K_NMI) ? NMI_VEC : IRQ_VEC;
      end
      if (state == S_VLO || state == S_RL) lo_q  <= (state == S_VLO) ? vec_data : pull_data;
      if (state == S_RP)                   pst_q <= pull_data;
    end
  end

  always_comb begin
    push_vld    = 1'b0;
    push_data   = '0;
    pull_vld    = 1'b0;
    vec_rd      = 1'b0;
    vec_addr    = '0;
    pc_load     = 1'b0;
    pc_out      = '0;
    status_load = 1'b0;
    status_out  = '0;
    unique case (state)
      S_PCH: begin push_vld = 1'b1; push_data = pc_q[AW-1:DW]; end
      S_PCL: begin push_vld = 1'b1; push_data = pc_q[DW-1:0]; end
      S_PSR: begin push_vld = 1'b1; push_data = DW'(stacked_status(st_q, brk_q)); end
      S_VLO: begin vec_rd = 1'b1; vec_addr = vbase_q; end
      S_VHI: begin
        vec_rd      = 1'b1;
        vec_addr    = {vbase_q[AW-1:1], 1'b1};
        pc_load     = 1'b1;
        pc_out      = {vec_data, lo_q};
        status_load = 1'b1;
        status_out  = entry_status(st_q);
      end
      S_RP, S_RL: pull_vld = 1'b1;
      S_RH: begin
        pull_vld    = 1'b1;
        pc_load     = 1'b1;
        pc_out      = {pull_data, lo_q};
        status_load = 1'b1;
        status_out  = restored_status(pst_q);
      end
      default: ;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/intr_seq.sv
`timescale 1ns/1ps
module intr_seq #(
  parameter int              DW      = 8,
  parameter logic [2*DW-1:0] NMI_VEC = 16'hFFFA,
  parameter logic [2*DW-1:0] IRQ_VEC = 16'hFFFE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi,
  input  logic            irq,
  input  logic            i_flag,
  input  logic            brk_req,
  input  logic            rti_req,
  input  logic [2*DW-1:0] pc_in,
  input  logic [7:0]      status_in,
  output logic            push_vld,
  output logic [DW-1:0]   push_data,
  output logic            pull_vld,
  input  logic [DW-1:0]   pull_data,
  output logic            vec_rd,
  output logic [2*DW-1:0] vec_addr,
  input  logic [DW-1:0]   vec_data,
  output logic            pc_load,
  output logic [2*DW-1:0] pc_out,
  output logic            status_load,
  output logic [7:0]      status_out,
  output logic            busy
);
  import intr_seq_pkg::*;

  logic  start, nmi_take;
  kind_e kind;

  intr_seq_arb u_arb (
    .clk(clk), .rst_n(rst_n), .idle(~busy), .nmi(nmi), .irq(irq),
    .i_flag(i_flag), .brk_req(brk_req), .rti_req(rti_req),
    .start(start), .kind(kind), .nmi_take(nmi_take)
  );

  intr_seq_fsm #(.DW(DW), .NMI_VEC(NMI_VEC), .IRQ_VEC(IRQ_VEC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
    .pc_in(pc_in), .status_in(status_in), .pull_data(pull_data), .vec_data(vec_data),
    .push_vld(push_vld), .push_data(push_data), .pull_vld(pull_vld),
    .vec_rd(vec_rd), .vec_addr(vec_addr), .pc_load(pc_load), .pc_out(pc_out),
    .status_load(status_load), .status_out(status_out), .busy(busy)
  );
endmodule

// File: rtl/intr_seq_chk.sv
`timescale 1ns/1ps
module intr_seq_chk #(
  parameter int              DW      = 8,
  parameter logic [2*DW-1:0] NMI_VEC = 16'hFFFA
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic            i_flag,
  input logic            brk_req,
  input logic            rti_req,
  input logic            nmi_take,
  input logic            busy,
  input logic            push_vld,
  input logic            pull_vld,
  input logic            vec_rd,
  input logic [2*DW-1:0] vec_addr,
  input logic            pc_load,
  input logic            status_load,
  input logic            st_i_bit
);
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(push_vld || pull_vld || vec_rd || pc_load || status_load)); // R1
  AST_PUSH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_vld) |=> push_vld ##1 push_vld); // R2
  AST_NO_PUSH_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_vld && pull_vld)); // R2
  AST_VEC_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(push_vld) |-> (vec_rd && !vec_addr[0])); // R4
  AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |-> ##4 (vec_addr == NMI_VEC)); // R5
  AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && irq && i_flag && !brk_req && !rti_req && !nmi_take) |=> !busy); // R6
  AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && vec_rd) |-> (status_load && st_i_bit)); // R9
  AST_PULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_vld) |=> pull_vld ##1 (pull_vld && pc_load)); // R10
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> busy); // R11
endmodule

bind intr_seq intr_seq_chk #(.DW(DW), .NMI_VEC(NMI_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .i_flag(i_flag), .brk_req(brk_req),
  .rti_req(rti_req), .nmi_take(nmi_take), .busy(busy), .push_vld(push_vld),
  .pull_vld(pull_vld), .vec_rd(vec_rd), .vec_addr(vec_addr), .pc_load(pc_load),
  .status_load(status_load), .st_i_bit(status_out[2])
);

// File: tb/intr_seq_test.sv
`timescale 1ns/1ps
module intr_seq_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, nmi, irq, i_flag, brk_req, rti_req;
  logic [15:0] pc_in;
  logic [7:0]  status_in;
  logic        push_vld, pull_vld, vec_rd, pc_load, status_load, busy;
  logic [7:0]  push_data, pull_data, vec_data, status_out;
  logic [15:0] vec_addr, pc_out;

  intr_seq uut (
    .clk(clk), .rst_n(rst_n), .nmi(nmi), .irq(irq), .i_flag(i_flag),
    .brk_req(brk_req), .rti_req(rti_req), .pc_in(pc_in), .status_in(status_in),
    .push_vld(push_vld), .push_data(push_data), .pull_vld(pull_vld),
    .pull_data(pull_data), .vec_rd(vec_rd), .vec_addr(vec_addr), .vec_data(vec_data),
    .pc_load(pc_load), .pc_out(pc_out), .status_load(status_load),
    .status_out(status_out), .busy(busy)
  );

  // vector memory: each byte is derived from its own address
  function automatic logic [7:0] vmem(input logic [15:0] a);
    return {a[3:0], ~a[3:0]};
  endfunction
  assign vec_data = vmem(vec_addr);

  // stack memory that the design writes and reads
  logic [7:0] stk [256];
  logic [7:0] sp = 8'hFF;
  assign pull_data = stk[sp + 8'd1];
  always @(posedge clk) begin
    if (push_vld) begin stk[sp] <= push_data; sp <= sp - 8'd1; end
    else if (pull_vld) sp <= sp + 8'd1;
  end

  // reference model
  typedef struct packed {
    logic        push_vld;
    logic [7:0]  push_data;
    logic        pull_vld;
    logic        vec_rd;
    logic [15:0] vec_addr;
    logic        pc_load;
    logic [15:0] pc_out;
    logic        status_load;
    logic [7:0]  status_out;
    logic        busy;
  } obs_t;

  obs_t       expq[$];
  string      tagq[$];
  logic [7:0] mstk [256];
  logic [7:0] msp = 8'hFF;
  logic       mprev = 1'b0, mpend = 1'b0;
  string      idle_tag = "R1";
  string      ctx = "reset";
  int         vectors = 0, misses = 0, cycles = 0;
  obs_t       act, ex;
  string      tg;

  task automatic add(input obs_t o, input string t);
    expq.push_back(o);
    tagq.push_back(t);
  endtask

  // kind: 0 maskable, 1 non-maskable, 2 break
  task automatic plan_entry(input int k);
    obs_t o;
    logic [15:0] pc, base;
    logic [7:0] s, ps;
    pc = pc_in; s = status_in;
    ps = s; ps[5] = 1'b1; ps[4] = (k == 2);
    base = (k == 1) ? 16'hFFFA : 16'hFFFE;
    o = '0; o.busy = 1'b1; o.push_vld = 1'b1;
    o.push_data = pc[15:8]; add(o, "R2 R11 pc-high");
    mstk[msp] = pc[15:8]; msp = msp - 8'd1;
    o.push_data = pc[7:0];  add(o, "R2 pc-low");
    mstk[msp] = pc[7:0];  msp = msp - 8'd1;
    o.push_data = ps;       add(o, (k == 2) ? "R3 status B=1" : "R3 status B=0");
    mstk[msp] = ps;       msp = msp - 8'd1;
    o = '0; o.busy = 1'b1; o.vec_rd = 1'b1; o.vec_addr = base;
    add(o, (k == 1) ? "R5 vec-low" : "R4 vec-low");
    o.vec_addr = base + 16'd1; o.pc_load = 1'b1;
    o.pc_out = {vmem(base + 16'd1), vmem(base)};
    o.status_load = 1'b1; o.status_out = s | 8'h04;
    add(o, (k == 1) ? "R5 R9 vec-high" : "R4 R9 vec-high");
  endtask

  task automatic plan_rti();
    obs_t o;
    logic [7:0] p, l, h;
    p = mstk[msp + 8'd1]; l = mstk[msp + 8'd2]; h = mstk[msp + 8'd3];
    msp = msp + 8'd3;
    o = '0; o.busy = 1'b1; o.pull_vld = 1'b1;
    add(o, "R10 R11 pull-status");
    add(o, "R10 pull-low");
    o.pc_load = 1'b1; o.pc_out = {h, l};
    o.status_load = 1'b1; o.status_out = (p & 8'hEF) | 8'h20;
    add(o, "R10 pull-high");
  endtask

  always @(negedge clk) begin
    cycles++;
    act = {push_vld, push_data, pull_vld, vec_rd, vec_addr, pc_load, pc_out,
           status_load, status_out, busy};
    if (!rst_n) begin
      ex = '0; tg = "R1 reset";
    end else if (expq.size() > 0) begin
      ex = expq.pop_front(); tg = tagq.pop_front();
    end else begin
      ex = '0; tg = idle_tag;
    end
    vectors++;
    if (act !== ex) begin
      misses++;
      $display("FAIL %s [%s] actual=%h expected=%h", tg, ctx, act, ex);
    end
    if (rst_n) begin
      if (nmi && !mprev) mpend = 1'b1;
      mprev = nmi;
      if (!ex.busy) begin
        if (mpend) begin mpend = 1'b0; plan_entry(1); end
        else if (irq && !i_flag) plan_entry(0);
        else if (brk_req) plan_entry(2);
        else if (rti_req) plan_rti();
      end
    end
    if (cycles > 5000) begin
      misses++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic preload(input logic [7:0] b);
    stk[sp] = b;  sp = sp - 8'd1;
    mstk[msp] = b; msp = msp - 8'd1;
  endtask

  initial begin
    rst_n = 1'b0; nmi = 0; irq = 0; i_flag = 0; brk_req = 0; rti_req = 0;
    pc_in = 16'h0000; status_in = 8'h00;
    tick(4);
    rst_n = 1'b1; ctx = "idle after reset";
    tick(3);

    ctx = "maskable entry";
    pc_in = 16'h1234; status_in = 8'h81; irq = 1; tick(1); irq = 0; tick(7);
    ctx = "return after maskable";
    rti_req = 1; tick(1); rti_req = 0; tick(5);

    ctx = "masked request"; idle_tag = "R6 masked";
    i_flag = 1; irq = 1; tick(10); irq = 0; i_flag = 0; idle_tag = "R1";

    ctx = "break entry";
    pc_in = 16'hABCD; status_in = 8'h0C; brk_req = 1; tick(1); brk_req = 0; tick(7);
    ctx = "return after break";
    rti_req = 1; tick(1); rti_req = 0; tick(5);

    ctx = "R7 held non-maskable level, mask set";
    i_flag = 1; pc_in = 16'h4000; status_in = 8'h04; nmi = 1; tick(20); nmi = 0;
    i_flag = 0; tick(3);
    rti_req = 1; tick(1); rti_req = 0; tick(5);

    ctx = "R8 collision nmi/irq/brk";
    pc_in = 16'h5A5A; status_in = 8'h40; nmi = 1; irq = 1; brk_req = 1;
    tick(1); irq = 0; brk_req = 0; tick(2); nmi = 0; tick(6);
    rti_req = 1; tick(1); rti_req = 0; tick(5);

    ctx = "R7 edge while busy";
    pc_in = 16'h0F0F; status_in = 8'h01; irq = 1; tick(1); irq = 0; tick(2);
    pc_in = 16'h7777; nmi = 1; tick(1); nmi = 0; tick(14);
    rti_req = 1; tick(1); rti_req = 0; tick(5);
    rti_req = 1; tick(1); rti_req = 0; tick(5);

    ctx = "R8 break beats return";
    pc_in = 16'hC3C3; status_in = 8'h02; brk_req = 1; rti_req = 1; tick(1);
    brk_req = 0; rti_req = 0; tick(7);
    rti_req = 1; tick(1); rti_req = 0; tick(5);

    ctx = "R10 return from preloaded stack";
    preload(8'hBE); preload(8'hEF); preload(8'hD3);
    rti_req = 1; tick(1); rti_req = 0; tick(5);

    ctx = "R11 requests while busy";
    pc_in = 16'h2468; status_in = 8'h00; brk_req = 1; tick(1); brk_req = 0;
    tick(1); rti_req = 1; tick(3); rti_req = 0; tick(5);
    tick(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule